// File: doc/BRIEF.md
# Load/Store Unit for a 32-bit Integer Pipeline

This block sits between the execute stage of a 32-bit integer pipeline and a word-wide data memory. It carries out five data-transfer operations: word load, word store, signed byte load, unsigned byte load and byte store. The pipeline presents one operation per cycle as a decoded 6-bit opcode, a base register value, a 16-bit offset and the store data.

The unit adds the sign-extended offset to the base to form the effective byte address. In the same cycle it issues a memory request with a word address, a four-bit lane mask and write data. A word operation whose address is not a multiple of four raises an alignment fault, and no request goes out.

The memory returns read data one cycle after a read request. In that cycle the unit presents the formatted load result. A byte load picks the addressed lane and extends it, and a word load passes the word through unchanged. A parameter selects how byte offsets map to lanes: big-endian (the default) or little-endian.

Top module: `ldst_unit`

## Requirements
- R1: The effective address is baseVal plus immOff sign-extended to 32 bits, wrapping modulo 2^32. On a request, memWordAddr carries effective-address bits 31:2.
- R2: Opcodes 35 (word load), 32 (signed byte load), 36 (unsigned byte load), 43 (word store) and 40 (byte store) issue a request when opValid is high. Any other opcode, or opValid low, gives memReq low and alignFault low.
- R3: A word load or word store whose effective-address bits 1:0 are not zero sets alignFault high in that cycle. It also keeps memReq and memWrite low, so there is no write and no later load result.
- R4: Byte operations are accepted at every byte offset and never set alignFault.
- R5: A word request drives memByteEn = 4'b1111. A word store drives memWdata = storeVal.
- R6: memByteEn bit i covers memory bits 8i+7:8i. A byte request sets exactly one bit. With BIG_ENDIAN=1, byte offset o (effective-address bits 1:0) selects bit 3-o. With BIG_ENDIAN=0, it selects bit o. A byte store places storeVal[7:0] on all four lanes of memWdata.
- R7: A signed byte load returns the selected lane in bits 7:0, with bits 31:8 filled from that byte's bit 7.
- R8: An unsigned byte load returns the selected lane in bits 7:0, with bits 31:8 at zero.
- R9: loadValid is high exactly in the cycle after an issued load request, and loadResult is formed from memRdata in that cycle. A word load returns memRdata unchanged. When loadValid is low, loadResult is zero.
- R10: memWrite is high only together with memReq, and only for word stores and byte stores.
- R11: While rst_n is low, loadValid is low, and it stays low in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 6 | Decoded primary opcode |
| baseVal | input | 32 | Base register value |
| immOff | input | 16 | Two's-complement offset |
| storeVal | input | 32 | Store source register value |
| memReq | output | 1 | Memory request this cycle |
| memWrite | output | 1 | Request is a write |
| memWordAddr | output | 30 | Word address (effective address bits 31:2) |
| memByteEn | output | 4 | Lane mask, bit i covers bits 8i+7:8i |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid one cycle after a read request |
| alignFault | output | 1 | Misaligned word operation this cycle |
| loadValid | output | 1 | loadResult is valid |
| loadResult | output | 32 | Formatted value for register write-back |

## Verification
The embedded properties assume the memory answers every read request after exactly one cycle, and that the pipeline presents at most one operation per cycle. They also assume opCode and baseVal are stable through the request cycle. The bench drives one operation per cycle on the falling edge and keeps it stable until the next falling edge. Its memory model returns read data on the clock edge that follows each read request.

Two instances, one big-endian and one little-endian, run the same stimulus. Each has its own memory model and its own behavioural reference. The stimulus includes directed cases: misaligned words, illegal opcodes, negative and wrapping offsets, and all four byte offsets. It also includes a pseudo-random mix of legal and illegal operations over a small aliased address window, so that loads read back earlier stores.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  localparam logic [5:0] OP_LW  = 6'd35;
  localparam logic [5:0] OP_LB  = 6'd32;
  localparam logic [5:0] OP_LBU = 6'd36;
  localparam logic [5:0] OP_SW  = 6'd43;
  localparam logic [5:0] OP_SB  = 6'd40;

  // control-to-datapath strobes
  typedef struct packed {
    logic go;     // issue a memory request
    logic wr;     // request writes memory
    logic word;   // full-word access
    logic sext;   // sign-extend a loaded byte
  } ldstStrobe_t;

endpackage

// File: rtl/ldst_ctrl.sv
module ldst_ctrl
  import ldst_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             opValid,
  input  logic [5:0]       opCode,
  input  logic [OFF_W-1:0] eaLow,
  output ldstStrobe_t      strb,
  output logic             alignFault
);

  logic known;
  logic isWord;
  logic isWr;
  logic isSext;
  logic misal;

  always_comb begin
    known  = 1'b1;
    isWord = 1'b0;
    isWr   = 1'b0;
    isSext = 1'b0;
    unique case (opCode)
      OP_LW:   isWord = 1'b1;
      OP_SW:   begin isWord = 1'b1; isWr = 1'b1; end
      OP_LB:   isSext = 1'b1;
      OP_LBU:  ;
      OP_SB:   isWr = 1'b1;
      default: known = 1'b0;
    endcase
  end

  assign misal      = isWord && (eaLow != '0);
  assign alignFault = opValid && known && misal;

  always_comb begin
    strb.go   = opValid && known && !misal;
    strb.wr   = isWr;
    strb.word = isWord;
    strb.sext = isSext;
  end

  // R4
  byte_never_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && (opCode == OP_LB || opCode == OP_LBU || opCode == OP_SB)) |-> !alignFault);

endmodule

// File: rtl/ldst_datapath.sv
module ldst_datapath
  import ldst_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int IMM_W      = 16,
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ldstStrobe_t         strb,
  input  logic [DATA_W-1:0]   baseVal,
  input  logic [IMM_W-1:0]    immOff,
  input  logic [DATA_W-1:0]   storeVal,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [$clog2(DATA_W/8)-1:0] eaLow,
  output logic                memReq,
  output logic                memWrite,
  output logic [DATA_W-$clog2(DATA_W/8)-1:0] memWordAddr,
  output logic [DATA_W/8-1:0] memByteEn,
  output logic [DATA_W-1:0]   memWdata,
  output logic                loadValid,
  output logic [DATA_W-1:0]   loadResult
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int EXT_W = DATA_W - IMM_W;
  localparam int FILL_W = DATA_W - 8;

  logic [DATA_W-1:0] effAddr;
  logic [OFF_W-1:0]  laneIdx;

  assign effAddr = baseVal + {{EXT_W{immOff[IMM_W-1]}}, immOff};
  assign eaLow   = effAddr[OFF_W-1:0];

  generate
    if (BIG_ENDIAN) begin : g_big
      assign laneIdx = OFF_W'(LANES - 1) - eaLow;
    end else begin : g_little
      assign laneIdx = eaLow;
    end
  endgenerate

  assign memReq      = strb.go;
  assign memWrite    = strb.go && strb.wr;
  assign memWordAddr = effAddr[DATA_W-1:OFF_W];
  assign memByteEn   = !strb.go ? '0 :
                       strb.word ? '1 : (LANES'(1) << laneIdx);
  assign memWdata    = strb.word ? storeVal : {LANES{storeVal[7:0]}};

  // response tracking
  logic             rspValid;
  logic             rspWord;
  logic             rspSext;
  logic [OFF_W-1:0] rspLane;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspWord  <= 1'b0;
      rspSext  <= 1'b0;
      rspLane  <= '0;
    end else begin
      rspValid <= strb.go && !strb.wr;
      rspWord  <= strb.word;
      rspSext  <= strb.sext;
      rspLane  <= laneIdx;
    end
  end

  logic [7:0] pickByte;
  assign pickByte = memRdata[{rspLane, 3'b000} +: 8];

  always_comb begin
    if (!rspValid)     loadResult = '0;
    else if (rspWord)  loadResult = memRdata;
    else if (rspSext)  loadResult = {{FILL_W{pickByte[7]}}, pickByte};
    else               loadResult = {{FILL_W{1'b0}}, pickByte};
  end
  assign loadValid = rspValid;

  // R6
  byte_lane_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !strb.word) |-> $onehot(memByteEn));

  // R5
  word_full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && strb.word) |-> (memByteEn == '1));

  // R9
  load_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loadValid |-> $past(memReq && !memWrite));

  // R10
  write_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memWrite |-> memReq);

endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
#(
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        opValid,
  input  logic [5:0]  opCode,
  input  logic [31:0] baseVal,
  input  logic [15:0] immOff,
  input  logic [31:0] storeVal,
  output logic        memReq,
  output logic        memWrite,
  output logic [29:0] memWordAddr,
  output logic [3:0]  memByteEn,
  output logic [31:0] memWdata,
  input  logic [31:0] memRdata,
  output logic        alignFault,
  output logic        loadValid,
  output logic [31:0] loadResult
);

  localparam int DATA_W = 32;
  localparam int IMM_W  = 16;
  localparam int OFF_W  = $clog2(DATA_W / 8);

  ldstStrobe_t      strb;
  logic [OFF_W-1:0] eaLow;

  ldst_ctrl #(.OFF_W(OFF_W)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .opValid    (opValid),
    .opCode     (opCode),
    .eaLow      (eaLow),
    .strb       (strb),
    .alignFault (alignFault)
  );

  ldst_datapath #(
    .DATA_W     (DATA_W),
    .IMM_W      (IMM_W),
    .BIG_ENDIAN (BIG_ENDIAN)
  ) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .baseVal     (baseVal),
    .immOff      (immOff),
    .storeVal    (storeVal),
    .memRdata    (memRdata),
    .eaLow       (eaLow),
    .memReq      (memReq),
    .memWrite    (memWrite),
    .memWordAddr (memWordAddr),
    .memByteEn   (memByteEn),
    .memWdata    (memWdata),
    .loadValid   (loadValid),
    .loadResult  (loadResult)
  );

  // R3
  misaligned_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alignFault |-> (!memReq && !memWrite));

  // R11
  quiet_after_reset_chk: assert property (@(posedge clk)
    !rst_n |=> !loadValid);

endmodule

// File: tb/ldst_unit_tb_top.sv
module ldst_unit_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        opValid;
  logic [5:0]  opCode;
  logic [31:0] baseVal;
  logic [15:0] immOff;
  logic [31:0] storeVal;

  logic [1:0]  memReq, memWrite, alignFault, loadValid;
  logic [29:0] memWordAddr [2];
  logic [3:0]  memByteEn   [2];
  logic [31:0] memWdata    [2];
  logic [31:0] memRdata    [2];
  logic [31:0] loadResult  [2];

  ldst_unit #(.BIG_ENDIAN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCode(opCode),
    .baseVal(baseVal), .immOff(immOff), .storeVal(storeVal),
    .memReq(memReq[0]), .memWrite(memWrite[0]), .memWordAddr(memWordAddr[0]),
    .memByteEn(memByteEn[0]), .memWdata(memWdata[0]), .memRdata(memRdata[0]),
    .alignFault(alignFault[0]), .loadValid(loadValid[0]), .loadResult(loadResult[0])
  );

  ldst_unit #(.BIG_ENDIAN(1'b0)) dutLe_i (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCode(opCode),
    .baseVal(baseVal), .immOff(immOff), .storeVal(storeVal),
    .memReq(memReq[1]), .memWrite(memWrite[1]), .memWordAddr(memWordAddr[1]),
    .memByteEn(memByteEn[1]), .memWdata(memWdata[1]), .memRdata(memRdata[1]),
    .alignFault(alignFault[1]), .loadValid(loadValid[1]), .loadResult(loadResult[1])
  );

  // memory models driven by each instance
  logic [31:0] envMem [2][16];
  logic [31:0] refMem [2][16];

  initial begin
    for (int e = 0; e < 2; e++) begin
      memRdata[e] = 32'h0;
      for (int w = 0; w < 16; w++) begin
        envMem[e][w] = 32'hA5C3_0000 + 32'(w * 32'h0101);
        refMem[e][w] = 32'hA5C3_0000 + 32'(w * 32'h0101);
      end
    end
  end

  always @(posedge clk) begin
    for (int e = 0; e < 2; e++) begin
      if (memReq[e]) begin
        if (memWrite[e]) begin
          for (int k = 0; k < 4; k++)
            if (memByteEn[e][k])
              envMem[e][memWordAddr[e][3:0]][8*k +: 8] <= memWdata[e][8*k +: 8];
        end else begin
          memRdata[e] <= envMem[e][memWordAddr[e][3:0]];
        end
      end
    end
  end

  int nCmp = 0;
  int nBad = 0;

  bit          expLdValid [2];
  logic [31:0] expLd      [2];
  string       expLdTag   [2];

  task automatic chk(string tag, int e, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s inst=%0d t=%0t actual=%h expected=%h", tag, e, $time, act, exp);
    end
  endtask

  function automatic int laneOf(int e, int off);
    return (e == 0) ? (3 - off) : off;
  endfunction

  task automatic step(bit v, logic [5:0] op, logic [31:0] base,
                      logic [15:0] imm, logic [31:0] sd);
    logic [31:0] ea;
    bit known, word, wr, fault, req;
    int lane;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] word_v;
    logic [7:0]  b;
    @(negedge clk);
    opValid = v; opCode = op; baseVal = base; immOff = imm; storeVal = sd;
    #5;
    ea    = base + {{16{imm[15]}}, imm};
    known = (op == 6'd35) || (op == 6'd32) || (op == 6'd36) || (op == 6'd43) || (op == 6'd40);
    word  = (op == 6'd35) || (op == 6'd43);
    wr    = (op == 6'd43) || (op == 6'd40);
    fault = v && known && word && (ea[1:0] != 2'b00);
    req   = v && known && !fault;
    for (int e = 0; e < 2; e++) begin
      // R9 / R11 response of previous cycle
      chk("R9 loadValid", e, {31'b0, loadValid[e]}, {31'b0, expLdValid[e]});
      if (expLdValid[e]) chk(expLdTag[e], e, loadResult[e], expLd[e]);
      else chk("R9 idle result", e, loadResult[e], 32'h0);
      // R2 / R3 / R4
      chk("R2 memReq", e, {31'b0, memReq[e]}, {31'b0, req});
      chk(word ? "R3 alignFault" : "R4 alignFault", e, {31'b0, alignFault[e]}, {31'b0, fault});
      lane = laneOf(e, int'(ea[1:0]));
      be   = word ? 4'hF : (4'b0001 << lane);
      wd   = word ? sd : {4{sd[7:0]}};
      if (req) begin
        chk("R1 wordAddr", e, {2'b0, memWordAddr[e]}, {2'b0, ea[31:2]});
        chk(word ? "R5 byteEn" : "R6 byteEn", e, {28'b0, memByteEn[e]}, {28'b0, be});
        chk("R10 memWrite", e, {31'b0, memWrite[e]}, {31'b0, wr});
        if (wr) chk(word ? "R5 wdata" : "R6 wdata", e, memWdata[e], wd);
      end else begin
        chk("R10 memWrite", e, {31'b0, memWrite[e]}, 32'h0);
      end
      // reference memory and expected load
      expLdValid[e] = req && !wr;
      if (req) begin
        word_v = refMem[e][ea[5:2]];
        if (wr) begin
          for (int k = 0; k < 4; k++)
            if (be[k]) refMem[e][ea[5:2]][8*k +: 8] = wd[8*k +: 8];
        end else begin
          b = word_v[8*lane +: 8];
          if (word) begin expLd[e] = word_v; expLdTag[e] = "R9 word load"; end
          else if (op == 6'd32) begin expLd[e] = {{24{b[7]}}, b}; expLdTag[e] = "R7 signed byte"; end
          else begin expLd[e] = {24'b0, b}; expLdTag[e] = "R8 unsigned byte"; end
        end
      end
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] lcg;
    logic [5:0]  ops [7];
    ops = '{6'd35, 6'd32, 6'd36, 6'd43, 6'd40, 6'd0, 6'd17};
    rst_n = 1'b0; opValid = 1'b0; opCode = '0; baseVal = '0; immOff = '0; storeVal = '0;
    for (int e = 0; e < 2; e++) begin expLdValid[e] = 0; expLd[e] = '0; expLdTag[e] = "R9"; end
    repeat (2) @(negedge clk);
    for (int e = 0; e < 2; e++) begin
      chk("R11 reset loadValid", e, {31'b0, loadValid[e]}, 32'h0);
      chk("R2 reset memReq", e, {31'b0, memReq[e]}, 32'h0);
    end
    rst_n = 1'b1;
    step(0, 6'd35, 32'h0, 16'h0, 32'h0);                 // R11 first cycle quiet
    // endianness check value
    step(1, 6'd43, 32'h0, 16'h0, 32'h2345_6789);
    step(1, 6'd32, 32'h0, 16'h1, 32'h0);                 // R6: 0x45 big, 0x67 little
    step(1, 6'd35, 32'h94, 16'd24, 32'h0);               // R1 ea 0xAC
    step(1, 6'd40, 32'h20, 16'hFFF9, 32'h0000_00F1);     // R1 base-7
    step(1, 6'd43, 32'h1C, 16'h0, 32'h8081_7F00);
    for (int o = 0; o < 4; o++) step(1, 6'd32, 32'h1C, 16'(o), 32'h0); // R7
    for (int o = 0; o < 4; o++) step(1, 6'd36, 32'h1C, 16'(o), 32'h0); // R8
    for (int o = 0; o < 4; o++) step(1, 6'd40, 32'h30, 16'(o), 32'hFFFF_FF10 + 32'(o)); // R6
    step(1, 6'd35, 32'h30, 16'h0, 32'h0);
    for (int o = 1; o < 4; o++) begin                    // R3 misaligned
      step(1, 6'd35, 32'h40, 16'(o), 32'h0);
      step(1, 6'd43, 32'h40, 16'(o), 32'hDEAD_BEEF);
    end
    step(1, 6'd35, 32'h40, 16'h0, 32'h0);                // store above suppressed
    step(1, 6'd0, 32'h0, 16'h0, 32'h1111_1111);          // R2 unknown
    step(1, 6'd63, 32'h0, 16'h0, 32'h1111_1111);
    step(1, 6'd33, 32'h4, 16'h0, 32'h1111_1111);
    step(1, 6'd35, 32'h0000_8004, 16'h8000, 32'h0);      // R1 ea 4
    step(1, 6'd43, 32'hFFFF_FFFC, 16'h8, 32'h0BAD_F00D);   // R1 wrap to 4
    step(1, 6'd35, 32'h4, 16'h0, 32'h0);
    lcg = 32'h1357_9BDF;
    for (int i = 0; i < 300; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      step(lcg[31:28] != 4'h0, ops[int'(lcg[27:25]) % 7],
           32'h100 + {26'b0, lcg[5:0]}, {{12{lcg[9]}}, lcg[9:6]}, {lcg[15:0], lcg[31:16]});
    end
    step(0, 6'd0, 32'h0, 16'h0, 32'h0);
    step(0, 6'd0, 32'h0, 16'h0, 32'h0);
    finishRun();
  end

endmodule